// File: doc/BRIEF.md
# Deferred Condition-Code Flag Evaluator

This block turns a saved arithmetic record into the four integer condition flags: negative (N), zero (Z), overflow (V) and carry (C). A processor core that postpones flag work keeps only three things after an operation retires: a class code naming the kind of operation, the 32-bit result and the 32-bit source operand. When a later instruction needs the flags, the core presents that record here together with a valid strobe. One clock later, a packed 4-bit flag vector comes back with its own valid.

The block never sees the destination operand from before the operation. For subtract-type classes it rebuilds the minuend as result plus source, adding one more for the extended form, and derives carry and overflow from that rebuilt value. For add-type classes it infers carry and overflow from the result and the source alone. Byte and word compares apply the subtract rule to the low 8 or 16 bits. The extended add and subtract classes also take the previous zero flag as an input, so that a zero outcome from a multi-word chain stays zero only when every earlier word was zero.

Top module: `ccf_eval`

## Requirements
- R1: While reset is held, and until the first strobe after it, out_valid, out_err and out_flags are all zero.
- R2: out_valid is high exactly one cycle after in_valid is high. out_flags and out_err change only in the cycle after a strobe, and otherwise hold their last value.
- R3: out_flags packs C in bit 0, V in bit 1, Z in bit 2 and N in bit 3. The class codes are: 0 raw, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-extended, 7 subtract-extended, 8 shift.
- R4: Raw class (0) copies in_result[3:0] to the flags unchanged.
- R5: Logic class (1) sets Z when the result is zero and N from result bit 31, and clears V and C.
- R6: Add class (2) sets C when the unsigned result is below the source. It sets V when the result's sign differs from the sign of the source and also from the sign of the other addend (result minus source). N and Z follow the result.
- R7: Subtract class (3) rebuilds the minuend M = result + source. It sets C when M is unsigned-below the source, and sets V when M's sign differs from the sign of the result and also from the sign of the source.
- R8: Byte compare (4) and word compare (5) apply the R7 rule to bits [7:0] and [15:0] of result and source. N, Z, C and V come only from those bits.
- R9: Add-extended class (6) sets C when the result is unsigned at or below the source. V uses the other addend computed as result - source - 1.
- R10: Subtract-extended class (7) rebuilds M = result + source + 1. It sets C when M is unsigned at or below the source. V follows the R7 sign rule.
- R11: Shift class (8) sets N and Z from the result, sets C when the full source word is non-zero, and clears V.
- R12: For classes 6 and 7, output Z is one only when the computed Z and in_old_z are both one. in_old_z has no effect on any other class.
- R13: Class codes 9 to 15 produce all-zero flags with out_err high. Every defined class produces out_err low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Evaluation request strobe |
| in_class | input | 4 | Operation class code |
| in_result | input | 32 | Saved result word (flag vector for raw class) |
| in_src | input | 32 | Saved source operand |
| in_old_z | input | 1 | Previous Z flag for extended classes |
| out_flags | output | 4 | Packed {N,Z,V,C} |
| out_valid | output | 1 | Flags valid, one cycle after the strobe |
| out_err | output | 1 | Unknown class code seen |

## Verification
Two events can share a cycle. The registered result of one request is presented on the outputs while the next request, often of a different class and width, is being captured. The bench provokes this with strobes on consecutive cycles whose classes change on every beat, mixed with idle gaps. A scoreboard queue in request order judges the stream: a stale or overwritten result shows up as a mismatch, and during every idle cycle the bench checks that the outputs hold their last value.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
   localparam int CLS_W  = 4;
   localparam int FLAG_W = 4;

   typedef enum logic [CLS_W-1:0] {
      CC_RAW   = 4'd0,
      CC_LOGIC = 4'd1,
      CC_ADD   = 4'd2,
      CC_SUB   = 4'd3,
      CC_CMP8  = 4'd4,
      CC_CMP16 = 4'd5,
      CC_ADDX  = 4'd6,
      CC_SUBX  = 4'd7,
      CC_SHIFT = 4'd8
   } cc_class_e;

   // bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C
   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } ccf_flags_t;

   // per-width subtract view
   typedef struct packed {
      logic n;
      logic z;
      logic sub_c;
      logic sub_v;
   } ccf_lane_t;
endpackage

// File: rtl/ccf_lane.sv
// Sign, zero and subtract-type carry/overflow for one operand width.
module ccf_lane #(
   parameter int W = 32
) (
   input  logic [W-1:0]     res,
   input  logic [W-1:0]     src,
   input  logic             ext,
   output ccf_pkg::ccf_lane_t lane
);
   localparam int MSB = W - 1;

   logic [W-1:0] minuend;
   logic [W-1:0] ov_vec;

   always_comb begin
      minuend    = res + src + {{(W-1){1'b0}}, ext};
      ov_vec     = (minuend ^ res) & (minuend ^ src);
      lane.n     = res[MSB];
      lane.z     = ~|res;
      lane.sub_c = ext ? (minuend <= src) : (minuend < src);
      lane.sub_v = ov_vec[MSB];
   end
endmodule

// File: rtl/ccf_addcv.sv
// Add-type carry/overflow inferred from result and one addend.
module ccf_addcv #(
   parameter int W = 32
) (
   input  logic [W-1:0] res,
   input  logic [W-1:0] src,
   input  logic         ext,
   output logic         add_c,
   output logic         add_v
);
   localparam int MSB = W - 1;

   logic [W-1:0] other;
   logic [W-1:0] ov_vec;

   always_comb begin
      other  = res - src - {{(W-1){1'b0}}, ext};
      ov_vec = (src ^ res) & ~(other ^ src);
      add_c  = ext ? (res <= src) : (res < src);
      add_v  = ov_vec[MSB];
   end
endmodule

// File: rtl/ccf_select.sv
// Combinational class decode and flag selection.
module ccf_select #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [ccf_pkg::CLS_W-1:0] cls,
   input  logic [DATA_W-1:0]         res,
   input  logic [DATA_W-1:0]         src,
   input  logic                      old_z,
   output ccf_pkg::ccf_flags_t       flags,
   output logic                      err
);
   import ccf_pkg::*;

   localparam int N_LANES = 3;

   logic      ext;
   logic      add_c, add_v;
   ccf_lane_t lanes [N_LANES];

   assign ext = (cls == CC_ADDX) || (cls == CC_SUBX);

   for (genvar gi = 0; gi < N_LANES; gi++) begin : g_lane
      localparam int LW = (gi == 0) ? DATA_W : ((gi == 1) ? HALF_W : BYTE_W);
      ccf_lane #(.W(LW)) u_lane (
         .res  (res[LW-1:0]),
         .src  (src[LW-1:0]),
         .ext  (ext),
         .lane (lanes[gi])
      );
   end

   ccf_addcv #(.W(DATA_W)) u_add (
      .res   (res),
      .src   (src),
      .ext   (ext),
      .add_c (add_c),
      .add_v (add_v)
   );

   always_comb begin
      flags = '0;
      err   = 1'b0;
      case (cls)
         CC_RAW:   flags = res[FLAG_W-1:0];
         CC_LOGIC: begin
            flags.n = lanes[0].n;
            flags.z = lanes[0].z;
         end
         CC_ADD, CC_ADDX: begin
            flags.n = lanes[0].n;
            flags.z = lanes[0].z & (~ext | old_z);
            flags.c = add_c;
            flags.v = add_v;
         end
         CC_SUB, CC_SUBX: begin
            flags.n = lanes[0].n;
            flags.z = lanes[0].z & (~ext | old_z);
            flags.c = lanes[0].sub_c;
            flags.v = lanes[0].sub_v;
         end
         CC_CMP16: begin
            flags.n = lanes[1].n;
            flags.z = lanes[1].z;
            flags.c = lanes[1].sub_c;
            flags.v = lanes[1].sub_v;
         end
         CC_CMP8: begin
            flags.n = lanes[2].n;
            flags.z = lanes[2].z;
            flags.c = lanes[2].sub_c;
            flags.v = lanes[2].sub_v;
         end
         CC_SHIFT: begin
            flags.n = lanes[0].n;
            flags.z = lanes[0].z;
            flags.c = |src;
         end
         default:  err = 1'b1;
      endcase
   end
endmodule

// File: rtl/ccf_stage.sv
// Output register: loads on strobe, holds otherwise.
module ccf_stage #(
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [FW-1:0] d_flags,
   input  logic          d_err,
   output logic [FW-1:0] q_flags,
   output logic          q_err,
   output logic          q_valid
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_flags <= '0;
         q_err   <= 1'b0;
         q_valid <= 1'b0;
      end else begin
         q_valid <= load;
         if (load) begin
            q_flags <= d_flags;
            q_err   <= d_err;
         end
      end
   end
endmodule

// File: rtl/ccf_eval.sv
module ccf_eval #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [ccf_pkg::CLS_W-1:0] in_class,
   input  logic [DATA_W-1:0]         in_result,
   input  logic [DATA_W-1:0]         in_src,
   input  logic                      in_old_z,
   output logic [ccf_pkg::FLAG_W-1:0] out_flags,
   output logic                      out_valid,
   output logic                      out_err
);
   import ccf_pkg::*;

   if (BYTE_W < 2 || HALF_W <= BYTE_W || DATA_W < HALF_W || DATA_W < FLAG_W) begin : g_bad_w
      $error("ccf_eval: widths must satisfy 2 <= BYTE_W < HALF_W <= DATA_W, DATA_W >= FLAG_W");
   end

   ccf_flags_t nxt_flags;
   logic       nxt_err;

   ccf_select #(.DATA_W(DATA_W), .HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_sel (
      .cls   (in_class),
      .res   (in_result),
      .src   (in_src),
      .old_z (in_old_z),
      .flags (nxt_flags),
      .err   (nxt_err)
   );

   ccf_stage #(.FW(FLAG_W)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (in_valid),
      .d_flags (nxt_flags),
      .d_err   (nxt_err),
      .q_flags (out_flags),
      .q_err   (out_err),
      .q_valid (out_valid)
   );
endmodule

// File: rtl/ccf_eval_chk.sv
module ccf_eval_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        in_class,
   input logic [DATA_W-1:0] in_result,
   input logic [DATA_W-1:0] in_src,
   input logic              in_old_z,
   input logic [3:0]        out_flags,
   input logic              out_valid,
   input logic              out_err
);
   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_flags) && $stable(out_err)));
   a_r4_raw_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 4'd0) |=> out_flags == $past(in_result[3:0]));
   a_r5_logic_vc: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 4'd1) |=> out_flags[1:0] == 2'b00);
   a_r11_shift_c: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class == 4'd8) |=>
         (out_flags[0] == ($past(in_src) != '0)) && !out_flags[1]);
   a_r12_sticky_z: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_class == 4'd6 || in_class == 4'd7) && !in_old_z) |=> !out_flags[2]);
   a_r13_unknown: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class > 4'd8) |=> (out_err && out_flags == 4'd0));
   a_r13_known_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_class <= 4'd8) |=> !out_err);
endmodule

bind ccf_eval ccf_eval_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_class  (in_class),
   .in_result (in_result),
   .in_src    (in_src),
   .in_old_z  (in_old_z),
   .out_flags (out_flags),
   .out_valid (out_valid),
   .out_err   (out_err)
);

// File: tb/tb_ccf_eval.sv
`timescale 1ns/1ps
module tb_ccf_eval;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [3:0]  in_class = '0;
   logic [31:0] in_result = '0;
   logic [31:0] in_src = '0;
   logic        in_old_z = 1'b0;
   logic [3:0]  out_flags;
   logic        out_valid;
   logic        out_err;

   int tests = 0;
   int fails = 0;
   bit done = 0;
   bit mon_on = 0;
   logic [3:0] last_f = '0;
   logic       last_e = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   typedef struct {
      logic [3:0] f;
      logic       e;
      string      tag;
   } exp_t;
   exp_t q[$];

   always #2.5 clk = ~clk;

   ccf_eval dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
      .in_result(in_result), .in_src(in_src), .in_old_z(in_old_z),
      .out_flags(out_flags), .out_valid(out_valid), .out_err(out_err)
   );

   function automatic logic [31:0] next_rand();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      return rng;
   endfunction

   // reference model written from the requirements
   function automatic logic [4:0] ref_model(input int cls, input logic [31:0] r,
                                            input logic [31:0] s, input logic oz);
      longint unsigned mask, sb, rr, ss, m, a;
      int w;
      logic n, z, v, c;
      w = (cls == 4) ? 8 : ((cls == 5) ? 16 : 32);
      mask = (64'd1 << w) - 1;
      sb   = 64'd1 << (w - 1);
      rr = r & mask; ss = s & mask;
      n = (rr & sb) != 0; z = (rr == 0); v = 0; c = 0;
      case (cls)
         0: return {1'b0, r[3:0]};
         1: ;
         2: begin a = (rr - ss) & mask; c = rr < ss; v = ((a ^ rr) & (ss ^ rr) & sb) != 0; end
         6: begin a = (rr - ss - 1) & mask; c = rr <= ss; v = ((a ^ rr) & (ss ^ rr) & sb) != 0; z = z & oz; end
         3, 4, 5: begin m = (rr + ss) & mask; c = m < ss; v = ((m ^ ss) & (m ^ rr) & sb) != 0; end
         7: begin m = (rr + ss + 1) & mask; c = m <= ss; v = ((m ^ ss) & (m ^ rr) & sb) != 0; z = z & oz; end
         8: c = (s != 0);
         default: return 5'b1_0000;
      endcase
      return {1'b0, n, z, v, c};
   endfunction

   task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual err/flags=%b expected %b", tag, act, exp);
      end
   endtask

   task automatic send(input int cls, input logic [31:0] r, input logic [31:0] s,
                       input logic oz, input string tag);
      exp_t it;
      logic [4:0] x;
      @(negedge clk);
      in_valid = 1'b1; in_class = cls[3:0]; in_result = r; in_src = s; in_old_z = oz;
      x = ref_model(cls, r, s, oz);
      it.e = x[4]; it.f = x[3:0]; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_class = next_rand()[3:0];
         in_result = next_rand();
      end
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (mon_on && !done) begin
         if (out_valid) begin
            if (q.size() == 0) begin
               check({out_err, out_flags}, 5'b11111, "R2 unexpected valid");
            end else begin
               exp_t it;
               it = q.pop_front();
               check({out_err, out_flags}, {it.e, it.f}, it.tag);
               last_f = out_flags; last_e = out_err;
            end
         end else begin
            check({out_err, out_flags}, {last_e, last_f}, "R2 hold when idle");
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check({out_valid, out_err, out_flags}, 6'b0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check({out_valid, out_err, out_flags}, 6'b0, "R1 after release");
      mon_on = 1;
      // directed corners
      send(0, 32'hFFFF_FFF5, 32'h0, 1'b0, "R4 raw pass (R3 packing)");
      send(1, 32'h0, 32'h5, 1'b0, "R5 logic zero");
      send(1, 32'h8000_0001, 32'hFFFF_FFFF, 1'b0, "R5 logic negative");
      send(2, 32'h8000_0000, 32'h1, 1'b0, "R6 add signed overflow");
      send(2, 32'h0, 32'h1, 1'b0, "R6 add carry to zero");
      idle(2);
      send(3, 32'h7FFF_FFFF, 32'h1, 1'b0, "R7 sub overflow");
      send(3, 32'hFFFF_FFFF, 32'h1, 1'b0, "R7 sub borrow");
      send(4, 32'hABCD_EF80, 32'h1234_5601, 1'b0, "R8 byte compare");
      send(4, 32'hFFFF_FF00, 32'h0000_00FF, 1'b0, "R8 byte compare zero high junk");
      send(5, 32'h1234_7FFF, 32'hFFFF_0001, 1'b0, "R8 word compare overflow");
      send(6, 32'h0, 32'h0, 1'b1, "R9 addx zero kept (R12)");
      send(6, 32'h0, 32'h0, 1'b0, "R12 addx zero cleared");
      send(6, 32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R9 addx boundary");
      send(7, 32'h0, 32'hFFFF_FFFF, 1'b1, "R10 subx carry");
      send(7, 32'h0, 32'h0, 1'b0, "R12 subx zero cleared");
      send(7, 32'h7FFF_FFFF, 32'h0, 1'b1, "R10 subx overflow");
      send(2, 32'h0, 32'h0, 1'b0, "R12 old_z ignored by add");
      send(8, 32'h0, 32'h1, 1'b0, "R11 shift carry");
      send(8, 32'h8000_0000, 32'h0, 1'b1, "R11 shift no carry");
      send(9, 32'h5, 32'h5, 1'b1, "R13 unknown class");
      send(15, 32'hF, 32'h0, 1'b0, "R13 unknown class top");
      send(1, 32'h1, 32'h0, 1'b0, "R13 error clears on known class");
      idle(3);
      // back-to-back and gapped mixed stream
      for (int i = 0; i < 400; i++) begin
         logic [31:0] k, r, s;
         int cls;
         k = next_rand();
         cls = (k[7:0] < 8'd12) ? (9 + k[9:8]) : int'(k[19:16]) % 9;
         r = next_rand();
         s = k[20] ? next_rand() : {28'd0, k[23:20]};
         if (k[24]) r = 32'h0;
         send(cls, r, s, k[25], "R2 mixed stream");
         if (k[27:26] == 2'b00) idle(1 + int'(k[29:28]));
      end
      idle(4);
      if (q.size() != 0) check(5'd0, 5'd31, "R2 results missing");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule